// File: doc/BRIEF.md
# Interlaced 525-line digital video stream generator

The block produces an endless 8-bit component video byte stream, widened to a 10-bit bus, for a video encoder running on a 27 MHz byte clock. It has a horizontal byte counter and a frame line counter. From these it builds the end-of-active and start-of-active timing reference codes for each line. It also fills horizontal and vertical blanking with black, and decides which lines of each interlaced field carry picture.

On picture lines it asks an external pixel source for one 32-bit word per pixel pair. The request carries the active line number, the field, and the pair index. Each of the word's four components is clamped, so that picture data can never look like a timing code. The bytes are then sent out in chroma-blue, luma, chroma-red, luma order.

All frame dimensions are parameters. The defaults give 1716 byte slots per line with 1440 active bytes. The odd field has 262 lines (6 blanking, 254 picture, 2 blanking) and the even field has 263 lines (7 blanking, 253 picture, 3 blanking). The byte count of the line prologue (everything before the first active byte) must be a multiple of four.

Top module: `ntsc_stream_gen`

## Requirements
- R1: `rst_n` is synchronous and active low. While it is sampled low, `vout` is 0 and `pix_req` is 0. The first clock edge after release outputs slot 0 of line 0 of the odd field, which is the first byte of a timing reference.
- R2: Let A be LINE_BYTES minus ACT_BYTES. Each line has LINE_BYTES slots. Slots 0..3 hold the end-of-active reference, slots A-4..A-1 hold the start-of-active reference, and slots A..LINE_BYTES-1 are the active region. A reference is the bytes 0xFF, 0x00, 0x00, XY. The slots between the two references carry filler.
- R3: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 on the left. F is 0 in the odd field and 1 in the even field. H is 1 in the end-of-active reference and 0 in the start-of-active reference. F and V describe the current line.
- R4: Lines 0..ODD-1 form the odd field and the remaining lines form the even field. Within each field, V is 1 for the first TOP lines and for the lines after the TOP+ACT picture lines. The defaults are 6/254/2 for the odd field and 7/253/3 for the even field.
- R5: Filler is 0x80 in even slots and 0x10 in odd slots. Filler is used in horizontal blanking and across the whole active region of lines with V=1.
- R6: On a line with V=0, `pix_req` is high for exactly one cycle while the byte counter is at slot A+4p-1, for each pair p from 0 to ACT_BYTES/4-1. While it is high, `pix_pair` equals p and `pix_line` equals {active line index within the field [7:0], F}, where the active line index counts from 0. `pix_req` is never high on lines with V=1.
- R7: The source drives `pix_word` in the cycle after the request. Pair p occupies slots A+4p..A+4p+3 with the components `pix_word[31:24]` (Cb), `[23:16]` (Y), `[15:8]` (Cr) and `[7:0]` (Y), in that order.
- R8: Every active byte is clamped to the range 0x10..0xF0.
- R9: `vout` is {byte, 2'b00} and comes from a register. After the k-th clock edge following reset release, `vout` carries stream byte k-1.
- R10: The byte counter, line counter, pair index and active line index wrap exactly at their last values, so the second and later frames repeat the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_word | input | 32 | Pixel pair word from the source, valid in the cycle after a request |
| pix_req | output | 1 | Pixel pair request, one cycle ahead of need |
| pix_line | output | 9 | {active line index [7:0], field bit} of the requested pair |
| pix_pair | output | 9 | Pixel pair index within the line |
| vout | output | 10 | Registered stream byte shifted left by two |

## Verification
The bench compares every output byte over several frames against a model of the line and field layout. This catches an off-by-one at the first or last picture line of either field, which would show up as a wrong V bit in a reference code. It also catches a counter that wraps one slot or one line late, which would shift the whole following frame. Pixel words are hashed from the line and pair, and garbage is driven whenever no request is pending. A design that requests in the wrong cycle, or reads the word in the wrong cycle, therefore emits wrong components. Directed words holding 0x00, 0xFF, 0x0F and 0xF1 exercise both clamp limits. A reset applied in mid-frame confirms that the stream restarts cleanly.

// File: rtl/ntsc_pkg.sv
// Shared types and helpers for the stream generator.
// Assumes 8-bit components and the 4-byte timing reference layout.
package ntsc_pkg;

    typedef enum logic [1:0] {
        SEG_EAV,
        SEG_BLANK,
        SEG_SAV,
        SEG_ACTIVE
    } seg_e;

    localparam logic [7:0] CLIP_LO = 8'h10;
    localparam logic [7:0] CLIP_HI = 8'hF0;
    localparam logic [7:0] FILL_C  = 8'h80;
    localparam logic [7:0] FILL_Y  = 8'h10;

    // Status byte of a timing reference with its protection bits.
    function automatic logic [7:0] xy_code(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Clamp an active component into the legal picture range.
    function automatic logic [7:0] clip_byte(input logic [7:0] b);
        if (b < CLIP_LO)
            return CLIP_LO;
        else if (b > CLIP_HI)
            return CLIP_HI;
        else
            return b;
    endfunction

endpackage

// File: rtl/ntsc_hv_timing.sv
// Horizontal byte counter and frame line counter with field/blanking decode.
// Assumes LINE_BYTES - ACT_BYTES is a multiple of 4 and at least 12.
module ntsc_hv_timing
    import ntsc_pkg::*;
#(
    parameter int LINE_BYTES = 1716,
    parameter int ACT_BYTES  = 1440,
    parameter int ODD_TOP    = 6,
    parameter int ODD_ACT    = 254,
    parameter int ODD_BOT    = 2,
    parameter int EVEN_TOP   = 7,
    parameter int EVEN_ACT   = 253,
    parameter int EVEN_BOT   = 3,
    localparam int HW        = $clog2(LINE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic          line_last,
    output logic          field_wrap,
    output logic          field,
    output logic          vblank,
    output seg_e          seg
);
    localparam int ODD_L  = ODD_TOP + ODD_ACT + ODD_BOT;
    localparam int FRAME  = ODD_L + EVEN_TOP + EVEN_ACT + EVEN_BOT;
    localparam int LW     = $clog2(FRAME);
    localparam int PROLOG = LINE_BYTES - ACT_BYTES;

    localparam logic [HW-1:0] H_LAST    = HW'(LINE_BYTES - 1);
    localparam logic [HW-1:0] H_BLK_BEG = HW'(4);
    localparam logic [HW-1:0] H_SAV_BEG = HW'(PROLOG - 4);
    localparam logic [HW-1:0] H_ACT_BEG = HW'(PROLOG);
    localparam logic [LW-1:0] L_ODD     = LW'(ODD_L);
    localparam logic [LW-1:0] L_LAST    = LW'(FRAME - 1);

    logic [LW-1:0] lcnt;
    logic [LW-1:0] rel, top_l, act_end;

    // Byte slot counter, wraps at the last slot of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt <= '0;
        else if (hcnt == H_LAST)
            hcnt <= '0;
        else
            hcnt <= hcnt + 1'b1;
    end

    // Frame line counter, advances at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lcnt <= '0;
        else if (line_last)
            lcnt <= (lcnt == L_LAST) ? '0 : lcnt + 1'b1;
    end

    // Field, vertical blanking and end-of-field decode.
    always_comb begin
        line_last  = (hcnt == H_LAST);
        field      = (lcnt >= L_ODD);
        rel        = field ? (lcnt - L_ODD) : lcnt;
        top_l      = field ? LW'(EVEN_TOP) : LW'(ODD_TOP);
        act_end    = field ? LW'(EVEN_TOP + EVEN_ACT) : LW'(ODD_TOP + ODD_ACT);
        vblank     = (rel < top_l) || (rel >= act_end);
        field_wrap = line_last && ((lcnt == L_ODD - 1'b1) || (lcnt == L_LAST));
    end

    // Segment of the line the current slot falls in.
    always_comb begin
        if (hcnt < H_BLK_BEG)
            seg = SEG_EAV;
        else if (hcnt < H_SAV_BEG)
            seg = SEG_BLANK;
        else if (hcnt < H_ACT_BEG)
            seg = SEG_SAV;
        else
            seg = SEG_ACTIVE;
    end

endmodule

// File: rtl/ntsc_pix_fetch.sv
// Issues pixel pair requests one slot early, tracks pair and active line
// indices, and picks the active component for the current slot.
// Assumes the source answers in the cycle after pix_req and that the
// prologue length is a multiple of 4, so slot bits [1:0] give the phase.
module ntsc_pix_fetch
    import ntsc_pkg::*;
#(
    parameter int LINE_BYTES = 1716,
    parameter int ACT_BYTES  = 1440,
    localparam int HW        = $clog2(LINE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcnt,
    input  logic          line_last,
    input  logic          field_wrap,
    input  logic          field,
    input  logic          vblank,
    input  seg_e          seg,
    input  logic [31:0]   pix_word,
    output logic          pix_req,
    output logic [8:0]    pix_line,
    output logic [8:0]    pix_pair,
    output logic [7:0]    act_byte
);
    localparam int PAIRS  = ACT_BYTES / 4;
    localparam int PROLOG = LINE_BYTES - ACT_BYTES;
    localparam logic [HW-1:0] REQ_FIRST = HW'(PROLOG - 1);
    localparam logic [HW-1:0] REQ_LAST  = HW'(LINE_BYTES - 2);
    localparam logic [8:0]    PAIR_LAST = 9'(PAIRS - 1);

    logic [8:0]  pair_q;
    logic [7:0]  aline_q;
    logic [31:0] word_q;

    // Request strobe on the slot before each pair's first byte.
    always_comb begin
        pix_req  = !vblank && (hcnt[1:0] == 2'b11) &&
                   (hcnt >= REQ_FIRST) && (hcnt <= REQ_LAST);
        pix_pair = pair_q;
        pix_line = {aline_q, field};
    end

    // Pair index, advances with each request and wraps at the last pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_q <= '0;
        else if (pix_req)
            pair_q <= (pair_q == PAIR_LAST) ? '0 : pair_q + 1'b1;
    end

    // Active line index within the field, cleared at each field end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aline_q <= '0;
        else if (field_wrap)
            aline_q <= '0;
        else if (line_last && !vblank)
            aline_q <= aline_q + 1'b1;
    end

    // Hold the returned word for the three bytes after its first one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (seg == SEG_ACTIVE && !vblank && hcnt[1:0] == 2'b00)
            word_q <= pix_word;
    end

    // Component select: the first byte comes straight from the source.
    always_comb begin
        unique case (hcnt[1:0])
            2'd0:    act_byte = pix_word[31:24];
            2'd1:    act_byte = word_q[23:16];
            2'd2:    act_byte = word_q[15:8];
            default: act_byte = word_q[7:0];
        endcase
    end

endmodule

// File: rtl/ntsc_byte_out.sv
// Chooses reference, filler or clamped picture byte and registers it.
// Assumes idx is the slot phase within a 4-byte reference.
module ntsc_byte_out
    import ntsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seg_e       seg,
    input  logic [1:0] idx,
    input  logic       field,
    input  logic       vblank,
    input  logic [7:0] act_byte,
    output logic [9:0] vout
);
    logic [7:0] nxt;
    logic [7:0] fill;
    logic [7:0] ref_b;

    // Next byte selection for the current slot.
    always_comb begin
        fill = idx[0] ? FILL_Y : FILL_C;
        unique case (idx)
            2'd0:    ref_b = 8'hFF;
            2'd1:    ref_b = 8'h00;
            2'd2:    ref_b = 8'h00;
            default: ref_b = xy_code(field, vblank, seg == SEG_EAV);
        endcase
        unique case (seg)
            SEG_EAV, SEG_SAV: nxt = ref_b;
            SEG_ACTIVE:       nxt = vblank ? fill : clip_byte(act_byte);
            default:          nxt = fill;
        endcase
    end

    // Output register, two low bits tied to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vout <= '0;
        else
            vout <= {nxt, 2'b00};
    end

endmodule

// File: rtl/ntsc_stream_gen.sv
// Top of the interlaced video stream generator: timing, fetch and output.
// Assumes a free-running byte clock and a source with one-cycle latency.
module ntsc_stream_gen
    import ntsc_pkg::*;
#(
    parameter int LINE_BYTES = 1716,
    parameter int ACT_BYTES  = 1440,
    parameter int ODD_TOP    = 6,
    parameter int ODD_ACT    = 254,
    parameter int ODD_BOT    = 2,
    parameter int EVEN_TOP   = 7,
    parameter int EVEN_ACT   = 253,
    parameter int EVEN_BOT   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pix_word,
    output logic        pix_req,
    output logic [8:0]  pix_line,
    output logic [8:0]  pix_pair,
    output logic [9:0]  vout
);
    localparam int HW = $clog2(LINE_BYTES);

    logic [HW-1:0] hcnt;
    logic          line_last, field_wrap, field, vblank;
    seg_e          seg;
    logic [7:0]    act_byte;

    ntsc_hv_timing #(
        .LINE_BYTES(LINE_BYTES), .ACT_BYTES(ACT_BYTES),
        .ODD_TOP(ODD_TOP), .ODD_ACT(ODD_ACT), .ODD_BOT(ODD_BOT),
        .EVEN_TOP(EVEN_TOP), .EVEN_ACT(EVEN_ACT), .EVEN_BOT(EVEN_BOT)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_last(line_last),
        .field_wrap(field_wrap), .field(field), .vblank(vblank), .seg(seg)
    );

    ntsc_pix_fetch #(
        .LINE_BYTES(LINE_BYTES), .ACT_BYTES(ACT_BYTES)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_last(line_last),
        .field_wrap(field_wrap), .field(field), .vblank(vblank), .seg(seg),
        .pix_word(pix_word), .pix_req(pix_req), .pix_line(pix_line),
        .pix_pair(pix_pair), .act_byte(act_byte)
    );

    ntsc_byte_out u_out (
        .clk(clk), .rst_n(rst_n), .seg(seg), .idx(hcnt[1:0]),
        .field(field), .vblank(vblank), .act_byte(act_byte), .vout(vout)
    );

endmodule

// File: rtl/ntsc_stream_chk.sv
// Protocol checks on the generator's ports, bound into the top module.
module ntsc_stream_chk #(
    parameter int PAIRS = 360
) (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] vout,
    input logic       pix_req,
    input logic [8:0] pix_pair
);
    // R9: the two low bits of the bus stay zero.
    a_r9_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        vout[1:0] == 2'b00);

    // R2: a leading 0xFF is always followed by 0x00.
    a_r2_ref_seq: assert property (@(posedge clk) disable iff (!rst_n)
        vout[9:2] == 8'hFF |=> vout[9:2] == 8'h00);

    // R3: the byte after FF 00 00 has its top bit set and consistent protection bits.
    a_r3_xy_prot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vout[9:2], 3) == 8'hFF && $past(vout[9:2], 2) == 8'h00 &&
         $past(vout[9:2], 1) == 8'h00)
        |-> (vout[9] && vout[5] == (vout[7] ^ vout[6]) &&
             vout[4] == (vout[8] ^ vout[6]) && vout[3] == (vout[8] ^ vout[7]) &&
             vout[2] == (vout[8] ^ vout[7] ^ vout[6])));

    // R6: a request never lasts more than one cycle.
    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> !pix_req);

    // R10: the pair index never leaves its range.
    a_r10_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_pair < 9'(PAIRS));

endmodule

bind ntsc_stream_gen ntsc_stream_chk #(.PAIRS(ACT_BYTES / 4)) u_chk (
    .clk(clk), .rst_n(rst_n), .vout(vout), .pix_req(pix_req), .pix_pair(pix_pair)
);

// File: tb/sim_ntsc_stream_gen.sv
module sim_ntsc_stream_gen;
    localparam int LB = 24, ACT = 8, A = LB - ACT;
    localparam int OT = 2, OA = 3, OB = 1, ET = 3, EA = 2, EB = 2;
    localparam int ODD = OT + OA + OB, LF = ODD + ET + EA + EB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pix_word = '0;
    logic        pix_req;
    logic [8:0]  pix_line, pix_pair;
    logic [9:0]  vout;
    int          checks = 0, errors = 0;
    logic [31:0] salt;

    ntsc_stream_gen #(
        .LINE_BYTES(LB), .ACT_BYTES(ACT), .ODD_TOP(OT), .ODD_ACT(OA), .ODD_BOT(OB),
        .EVEN_TOP(ET), .EVEN_ACT(EA), .EVEN_BOT(EB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .pix_req(pix_req),
        .pix_line(pix_line), .pix_pair(pix_pair), .vout(vout)
    );

    initial forever #10 clk = ~clk;

    function automatic logic [31:0] word_of(logic [8:0] li, logic [8:0] p);
        logic [31:0] w;
        w = ({23'd0, li} * 32'h9E3779B1) ^ ({23'd0, p} * 32'h85EBCA77) ^ salt;
        w = w ^ (w >> 13) ^ (w << 7);
        if (li[8:1] == 8'd0 && p == 9'd0) w = 32'h00FF_0FF1;
        if (li[8:1] == 8'd1 && p == 9'd1) w = 32'hFF10_F0EF;
        return w;
    endfunction

    function automatic logic [7:0] xyc(bit f, bit v, bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] clipb(logic [7:0] b);
        return (b < 8'h10) ? 8'h10 : (b > 8'hF0) ? 8'hF0 : b;
    endfunction

    // Expected byte, tag and request for stream position k.
    task automatic model(input int k, output logic [7:0] b, output string tag,
                         output bit rq, output logic [8:0] rl, output logic [8:0] rp);
        int s, l, rel, top, ae, al, ph;
        bit f, vb;
        logic [31:0] w;
        s = k % LB; l = (k / LB) % LF;
        f = (l >= ODD); rel = f ? l - ODD : l;
        top = f ? ET : OT; ae = top + (f ? EA : OA);
        vb = (rel < top) || (rel >= ae); al = rel - top;
        rl = {al[7:0], f}; rp = 9'((s + 1 - A) / 4);
        rq = !vb && (s % 4 == 3) && (s >= A - 1) && (s <= LB - 2);
        if (s < 4) begin
            b = (s == 0) ? 8'hFF : (s < 3) ? 8'h00 : xyc(f, vb, 1'b1);
            tag = (l == 0 && k >= LB * LF) ? "R10" : ((s == 3) ? "R3" : "R2");
        end else if (s < A - 4) begin
            b = (s % 2) ? 8'h10 : 8'h80; tag = "R2";
        end else if (s < A) begin
            b = (s == A - 4) ? 8'hFF : (s < A - 1) ? 8'h00 : xyc(f, vb, 1'b0);
            tag = (s == A - 1) ? "R4" : "R2";
        end else if (vb) begin
            b = (s % 2) ? 8'h10 : 8'h80; tag = "R5";
        end else begin
            ph = (s - A) % 4;
            w = word_of(rl, 9'((s - A) / 4));
            b = clipb(w[31 - 8*ph -: 8]);
            tag = (ph == 0) ? "R7" : "R8";
        end
        if (k == 0) tag = "R1";
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Release reset and follow the stream for n cycles.
    task automatic run(int n);
        logic [7:0] b; string tag; bit rq; logic [8:0] rl, rp;
        @(negedge clk); rst_n = 1'b1;
        model(0, b, tag, rq, rl, rp);
        chk("R6", {31'd0, pix_req}, {31'd0, rq});
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            model(k - 1, b, tag, rq, rl, rp);
            chk(tag, {22'd0, vout}, {22'd0, b, 2'b00});
            chk("R9", {30'd0, vout[1:0]}, 32'd0);
            model(k, b, tag, rq, rl, rp);
            chk("R6", {31'd0, pix_req}, {31'd0, rq});
            if (rq) begin
                chk("R6", {23'd0, pix_pair}, {23'd0, rp});
                chk("R6", {23'd0, pix_line}, {23'd0, rl});
            end
        end
    endtask

    task automatic hold_reset(int n);
        @(negedge clk); rst_n = 1'b0;
        repeat (n) @(negedge clk);
        chk("R1", {22'd0, vout}, 32'd0);
        chk("R1", {31'd0, pix_req}, 32'd0);
    endtask

    // Pixel source: answers requests one cycle later, garbage otherwise.
    initial forever begin
        @(posedge clk);
        if (pix_req) pix_word <= word_of(pix_line, pix_pair);
        else         pix_word <= $urandom;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 stream run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        salt = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        chk("R1", {22'd0, vout}, 32'd0);
        chk("R1", {31'd0, pix_req}, 32'd0);
        run(2 * LF * LB + 37);
        hold_reset(3);
        run(LF * LB + 2 * LB + $urandom_range(0, 40));
        hold_reset(2);
        run(LB + 5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule